// File: doc/BRIEF.md
# Performance Monitor Branch Unit

This block sits beside a processor's performance counters and turns their overflow alerts into a branch into a handler that user code installs itself. It holds four 64-bit registers: a monitor control register, a branch status register, a return-address register and a handler-address register. An alert from any counter can update the control register's freeze and alert bits. It can also leave an interrupt pending.

The pending interrupt is taken only while the core runs in user (problem) state. When it is taken and the status register allows it, the block sends a one-cycle redirect strobe with the handler address as the target. It saves the current instruction address in the return register and marks the event in the status register. The privilege level does not change.

Software reads and writes the four registers through one write port, which has a select field, and through four read buses that are always visible.

Top module: `perfmon_branch_unit`

## Requirements
- R1: After a synchronous active-high reset, all four registers read zero and `redirect_o`, `redirect_pc_o` and `freeze_o` are zero.
- R2: An alert has no effect while control bit 0 (branch enable) is clear: the control register keeps its value and no interrupt becomes pending, so no redirect follows.
- R3: On an accepted alert with control bit 1 (freeze arm) set, bit 1 is cleared and bit 2 (freeze) is set. `freeze_o` shows control bit 2.
- R4: On an accepted alert with control bit 3 (alert enable) set, bit 3 is cleared and bit 4 (alert seen) is set.
- R5: An accepted alert makes an interrupt pending. The interrupt is serviced only in a cycle with `user_mode_i` high. While `user_mode_i` is low it stays pending for as long as needed.
- R6: Servicing always clears the pending flag. It redirects only if status bit 0 (global enable) and status bit 1 (monitor enable) are both set. Otherwise the interrupt is dropped and does not come back.
- R7: A redirect is registered. In the cycle after the service cycle, `redirect_o` is high for that one cycle and `redirect_pc_o` equals the handler register. The return register holds the `cur_pc_i` of the service cycle, status bit 0 is clear and status bit 2 (event hit) is set.
- R8: Any one of the `NUM_ALERTS` alert inputs, alone, is enough to raise an alert.
- R9: In a cycle with a register write, alert acceptance and the redirect decision use the written value. In a status-register write that meets a redirect, the hardware updates of bits 0 and 2 win.
- R10: An alert that arrives in a service cycle makes the interrupt pending again once the old one is cleared, so a later user-state cycle services it.
- R11: With `wr_en_i` high, `wr_sel_i` picks the target register: 0 control, 1 status, 2 return, 3 handler. The whole 64-bit value shows on the matching read bus after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alert_i | input | NUM_ALERTS | Counter overflow alert, one per counter |
| user_mode_i | input | 1 | High while the core runs in user state |
| cur_pc_i | input | 64 | Address of the current instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 64 | Write data |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | 64 | Redirect target address |
| freeze_o | output | 1 | Counter freeze request |
| ctl_o | output | 64 | Control register value |
| stat_o | output | 64 | Status register value |
| ret_o | output | 64 | Return-address register value |
| hdl_o | output | 64 | Handler-address register value |

## Verification
The bench builds the block with its default of five alert inputs. This lets it drive each line alone in a directed sweep and drive random mixes of several lines at once. The registers keep their full 64-bit width, so random handler and instruction addresses cover the whole word when they pass through the return and target paths. The directed cases cover two situations: a write that lands in the same cycle as an alert or a redirect, and an alert that arrives in a service cycle. A long random phase that favours the low control and status bits then mixes privilege changes, writes and alerts freely.

// File: rtl/perfmon_branch_pkg.sv
package perfmon_branch_pkg;

    localparam int unsigned REG_W    = 64;
    localparam int unsigned NUM_REGS = 4;
    localparam int unsigned SEL_W    = $clog2(NUM_REGS);

    // control register fields
    localparam int unsigned CTL_BR_EN      = 0;
    localparam int unsigned CTL_FRZ_ARM    = 1;
    localparam int unsigned CTL_FRZ        = 2;
    localparam int unsigned CTL_ALERT_EN   = 3;
    localparam int unsigned CTL_ALERT_SEEN = 4;

    // status register fields
    localparam int unsigned ST_GLB_EN  = 0;
    localparam int unsigned ST_MON_EN  = 1;
    localparam int unsigned ST_MON_HIT = 2;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [SEL_W-1:0] {
        REG_CTL  = 2'd0,
        REG_STAT = 2'd1,
        REG_RET  = 2'd2,
        REG_HDL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
        reg_t     data;
    } reg_wr_t;

    typedef struct packed {
        reg_t stat;
        reg_t ret;
        reg_t hdl;
        reg_t tgt;
        logic redirect;
    } seq_state_t;

    // value after a software write, if any
    function automatic reg_t merge_write(reg_t cur, logic hit, reg_t data);
        return hit ? data : cur;
    endfunction

    // control register side effects of an accepted alert
    function automatic reg_t ctl_on_alert(reg_t c);
        reg_t r;
        r = c;
        if (c[CTL_FRZ_ARM]) begin
            r[CTL_FRZ_ARM] = 1'b0;
            r[CTL_FRZ]     = 1'b1;
        end
        if (c[CTL_ALERT_EN]) begin
            r[CTL_ALERT_EN]   = 1'b0;
            r[CTL_ALERT_SEEN] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic branch_armed(reg_t s);
        return s[ST_GLB_EN] & s[ST_MON_EN];
    endfunction

    // status register side effects of a redirect
    function automatic reg_t stat_on_redirect(reg_t s);
        reg_t r;
        r = s;
        r[ST_GLB_EN]  = 1'b0;
        r[ST_MON_HIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/perfmon_wr_decode.sv
module perfmon_wr_decode
    import perfmon_branch_pkg::*;
(
    input  logic                en_i,
    input  reg_sel_e            sel_i,
    output logic [NUM_REGS-1:0] hit_o
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit_o[g] = en_i && (sel_i == reg_sel_e'(g));
    end

endmodule

// File: rtl/perfmon_alert_ctl.sv
module perfmon_alert_ctl
    import perfmon_branch_pkg::*;
#(
    parameter int unsigned NUM_ALERTS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_ALERTS-1:0] alert_i,
    input  logic                  ctl_wr_i,
    input  reg_t                  wr_data_i,
    input  logic                  service_i,
    output reg_t                  ctl_q_o,
    output logic                  pending_q_o
);

    reg_t ctl_q;
    reg_t ctl_eff;
    reg_t ctl_d;
    logic any_alert;
    logic accept;
    logic pend_q;
    logic pend_d;

    always_comb begin
        any_alert = |alert_i;
        ctl_eff   = merge_write(ctl_q, ctl_wr_i, wr_data_i);
        accept    = any_alert & ctl_eff[CTL_BR_EN];
        ctl_d     = accept ? ctl_on_alert(ctl_eff) : ctl_eff;
        // service clears the old request; a new alert sets it again
        pend_d    = accept | (pend_q & ~service_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            pend_q <= pend_d;
        end
    end

    assign ctl_q_o     = ctl_q;
    assign pending_q_o = pend_q;

endmodule

// File: rtl/perfmon_branch_seq.sv
module perfmon_branch_seq
    import perfmon_branch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pending_i,
    input  logic user_mode_i,
    input  reg_t cur_pc_i,
    input  logic stat_wr_i,
    input  logic ret_wr_i,
    input  logic hdl_wr_i,
    input  reg_t wr_data_i,
    output logic service_o,
    output reg_t stat_o,
    output reg_t ret_o,
    output reg_t hdl_o,
    output logic redirect_o,
    output reg_t redirect_pc_o
);

    seq_state_t st_q;
    seq_state_t st_d;
    logic       service;
    logic       take;

    always_comb begin
        st_d.stat = merge_write(st_q.stat, stat_wr_i, wr_data_i);
        st_d.ret  = merge_write(st_q.ret,  ret_wr_i,  wr_data_i);
        st_d.hdl  = merge_write(st_q.hdl,  hdl_wr_i,  wr_data_i);
        st_d.tgt  = st_q.tgt;
        service   = pending_i & user_mode_i;
        take      = service & branch_armed(st_d.stat);
        if (take) begin
            st_d.stat = stat_on_redirect(st_d.stat);
            st_d.ret  = cur_pc_i;
            st_d.tgt  = st_d.hdl;
        end
        st_d.redirect = take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign service_o     = service;
    assign stat_o        = st_q.stat;
    assign ret_o         = st_q.ret;
    assign hdl_o         = st_q.hdl;
    assign redirect_o    = st_q.redirect;
    assign redirect_pc_o = st_q.tgt;

endmodule

// File: rtl/perfmon_branch_unit.sv
module perfmon_branch_unit
    import perfmon_branch_pkg::*;
#(
    parameter int unsigned NUM_ALERTS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_ALERTS-1:0] alert_i,
    input  logic                  user_mode_i,
    input  logic [REG_W-1:0]      cur_pc_i,
    input  logic                  wr_en_i,
    input  logic [SEL_W-1:0]      wr_sel_i,
    input  logic [REG_W-1:0]      wr_data_i,
    output logic                  redirect_o,
    output logic [REG_W-1:0]      redirect_pc_o,
    output logic                  freeze_o,
    output logic [REG_W-1:0]      ctl_o,
    output logic [REG_W-1:0]      stat_o,
    output logic [REG_W-1:0]      ret_o,
    output logic [REG_W-1:0]      hdl_o
);

    reg_wr_t             wr;
    logic [NUM_REGS-1:0] wr_hit;
    logic                pending;
    logic                service;
    reg_t                ctl_q;

    assign wr.en   = wr_en_i;
    assign wr.sel  = reg_sel_e'(wr_sel_i);
    assign wr.data = wr_data_i;

    perfmon_wr_decode i_decode (
        .en_i  (wr.en),
        .sel_i (wr.sel),
        .hit_o (wr_hit)
    );

    perfmon_alert_ctl #(
        .NUM_ALERTS (NUM_ALERTS)
    ) i_alert (
        .clk         (clk),
        .rst         (rst),
        .alert_i     (alert_i),
        .ctl_wr_i    (wr_hit[int'(REG_CTL)]),
        .wr_data_i   (wr.data),
        .service_i   (service),
        .ctl_q_o     (ctl_q),
        .pending_q_o (pending)
    );

    perfmon_branch_seq i_seq (
        .clk           (clk),
        .rst           (rst),
        .pending_i     (pending),
        .user_mode_i   (user_mode_i),
        .cur_pc_i      (cur_pc_i),
        .stat_wr_i     (wr_hit[int'(REG_STAT)]),
        .ret_wr_i      (wr_hit[int'(REG_RET)]),
        .hdl_wr_i      (wr_hit[int'(REG_HDL)]),
        .wr_data_i     (wr.data),
        .service_o     (service),
        .stat_o        (stat_o),
        .ret_o         (ret_o),
        .hdl_o         (hdl_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    assign ctl_o    = ctl_q;
    assign freeze_o = ctl_q[CTL_FRZ];

endmodule

// File: rtl/perfmon_branch_unit_chk.sv
module perfmon_branch_unit_chk
    import perfmon_branch_pkg::*;
#(
    parameter int unsigned NUM_ALERTS = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_ALERTS-1:0] alert_i,
    input logic                  user_mode_i,
    input logic [REG_W-1:0]      cur_pc_i,
    input logic                  wr_en_i,
    input logic [SEL_W-1:0]      wr_sel_i,
    input logic                  redirect_o,
    input logic [REG_W-1:0]      redirect_pc_o,
    input logic [REG_W-1:0]      ctl_o,
    input logic [REG_W-1:0]      stat_o,
    input logic [REG_W-1:0]      ret_o,
    input logic [REG_W-1:0]      hdl_o
);

    logic ctl_wr;
    logic stat_wr;
    logic hdl_wr;

    assign ctl_wr  = wr_en_i && (wr_sel_i == REG_CTL);
    assign stat_wr = wr_en_i && (wr_sel_i == REG_STAT);
    assign hdl_wr  = wr_en_i && (wr_sel_i == REG_HDL);

    assert_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl_o[CTL_BR_EN] && !ctl_wr) |=> $stable(ctl_o));

    assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_o[CTL_BR_EN] && ctl_o[CTL_FRZ_ARM] && (|alert_i) && !ctl_wr)
        |=> (ctl_o[CTL_FRZ] && !ctl_o[CTL_FRZ_ARM]));

    assert_alert_seen_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_o[CTL_BR_EN] && ctl_o[CTL_ALERT_EN] && (|alert_i) && !ctl_wr)
        |=> (ctl_o[CTL_ALERT_SEEN] && !ctl_o[CTL_ALERT_EN]));

    assert_user_only_R5: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> $past(user_mode_i));

    assert_armed_R6: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !$past(stat_wr))
        |-> $past(stat_o[ST_GLB_EN] && stat_o[ST_MON_EN]));

    assert_status_R7: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (!stat_o[ST_GLB_EN] && stat_o[ST_MON_HIT]));

    assert_return_R7: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (ret_o == $past(cur_pc_i)));

    assert_target_R7: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !$past(hdl_wr)) |-> (redirect_pc_o == $past(hdl_o)));

endmodule

bind perfmon_branch_unit perfmon_branch_unit_chk #(
    .NUM_ALERTS (NUM_ALERTS)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .alert_i       (alert_i),
    .user_mode_i   (user_mode_i),
    .cur_pc_i      (cur_pc_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .ctl_o         (ctl_o),
    .stat_o        (stat_o),
    .ret_o         (ret_o),
    .hdl_o         (hdl_o)
);

// File: tb/test_perfmon_branch_unit.sv
module test_perfmon_branch_unit;

    localparam int NA = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NA-1:0] alert = '0;
    logic          user = 1'b0;
    logic [63:0]   pc = '0;
    logic          we = 1'b0;
    logic [1:0]    sel = '0;
    logic [63:0]   wd = '0;
    logic          redirect_o;
    logic [63:0]   redirect_pc_o;
    logic          freeze_o;
    logic [63:0]   ctl_o, stat_o, ret_o, hdl_o;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [63:0] m_ctl = '0, m_stat = '0, m_ret = '0, m_hdl = '0, m_tgt = '0;
    logic        m_pend = 1'b0, m_redir = 1'b0;

    always #5 clk = ~clk;

    perfmon_branch_unit #(.NUM_ALERTS(NA)) i_perfmon_branch_unit (
        .clk (clk), .rst (rst), .alert_i (alert), .user_mode_i (user),
        .cur_pc_i (pc), .wr_en_i (we), .wr_sel_i (sel), .wr_data_i (wd),
        .redirect_o (redirect_o), .redirect_pc_o (redirect_pc_o),
        .freeze_o (freeze_o), .ctl_o (ctl_o), .stat_o (stat_o),
        .ret_o (ret_o), .hdl_o (hdl_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // next model state, from the requirements
    task automatic model_tick(input logic [NA-1:0] al, input logic usr, input logic [63:0] p,
                              input logic w, input logic [1:0] s, input logic [63:0] d);
        logic [63:0] c, st, r, h;
        logic acc, serv, take;
        c  = (w && s == 2'd0) ? d : m_ctl;
        st = (w && s == 2'd1) ? d : m_stat;
        r  = (w && s == 2'd2) ? d : m_ret;
        h  = (w && s == 2'd3) ? d : m_hdl;
        acc = (|al) && c[0];
        if (acc) begin
            if (c[1]) begin c[1] = 1'b0; c[2] = 1'b1; end
            if (c[3]) begin c[3] = 1'b0; c[4] = 1'b1; end
        end
        serv = m_pend && usr;
        take = serv && st[0] && st[1];
        if (take) begin
            st[0] = 1'b0;
            st[2] = 1'b1;
            r = p;
            m_tgt = h;
        end
        m_redir = take;
        m_pend  = acc | (m_pend & ~serv);
        m_ctl = c; m_stat = st; m_ret = r; m_hdl = h;
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " redirect"}, 64'(redirect_o), 64'(m_redir));
        chk({tag, " target"}, redirect_pc_o, m_tgt);
        chk({tag, " freeze"}, 64'(freeze_o), 64'(m_ctl[2]));
        chk({tag, " ctl"}, ctl_o, m_ctl);
        chk({tag, " stat"}, stat_o, m_stat);
        chk({tag, " ret"}, ret_o, m_ret);
        chk({tag, " hdl"}, hdl_o, m_hdl);
    endtask

    task automatic step(input string tag, input logic [NA-1:0] al, input logic usr,
                        input logic [63:0] p, input logic w, input logic [1:0] s,
                        input logic [63:0] d);
        alert = al; user = usr; pc = p; we = w; sel = s; wd = d;
        model_tick(al, usr, p, w, s, d);
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic wr(input string tag, input logic [1:0] s, input logic [63:0] d);
        step(tag, '0, 1'b0, 64'h0, 1'b1, s, d);
    endtask

    task automatic idle(input string tag, input logic usr, input logic [63:0] p);
        step(tag, '0, usr, p, 1'b0, 2'd0, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        compare_all("R1 reset");
        chk("R1 ctl zero", ctl_o, 64'h0);
        rst = 1'b0;

        // R11: register access by select
        wr("R11 hdl write", 2'd3, 64'h0000_0000_0000_1000);
        chk("R11 hdl readback", hdl_o, 64'h1000);
        wr("R11 ret write", 2'd2, 64'hDEAD_BEEF_0123_4567);
        chk("R11 ret readback", ret_o, 64'hDEAD_BEEF_0123_4567);

        // R2: alert ignored while branch enable is clear
        step("R2 alert off", 5'b00001, 1'b0, 64'h0, 1'b0, 2'd0, 64'h0);
        chk("R2 ctl unchanged", ctl_o, 64'h0);
        wr("R2 arm status", 2'd1, 64'h3);
        idle("R2 user", 1'b1, 64'h2000);
        idle("R2 user", 1'b1, 64'h2004);
        chk("R2 no redirect", 64'(redirect_o), 64'h0);

        // R3, R4: side effects of an accepted alert
        wr("R3 ctl setup", 2'd0, 64'hB);
        step("R3 alert", 5'b00100, 1'b0, 64'h0, 1'b0, 2'd0, 64'h0);
        chk("R3 R4 ctl after alert", ctl_o, 64'h15);
        chk("R3 freeze out", 64'(freeze_o), 64'h1);

        // R5: pending held in supervisor state
        for (int i = 0; i < 3; i++) begin
            idle("R5 supervisor", 1'b0, 64'h3000);
            chk("R5 held", 64'(redirect_o), 64'h0);
        end
        // R7: redirect effects
        idle("R7 service", 1'b1, 64'h4000);
        chk("R7 redirect", 64'(redirect_o), 64'h1);
        chk("R7 target", redirect_pc_o, 64'h1000);
        chk("R7 return", ret_o, 64'h4000);
        chk("R7 status", stat_o, 64'h6);
        idle("R7 pulse", 1'b1, 64'h4004);
        chk("R7 single pulse", 64'(redirect_o), 64'h0);

        // R6: service without global enable drops the interrupt
        wr("R6 status", 2'd1, 64'h2);
        wr("R6 ctl", 2'd0, 64'h1);
        step("R6 alert", 5'b00010, 1'b0, 64'h0, 1'b0, 2'd0, 64'h0);
        idle("R6 service", 1'b1, 64'h5000);
        chk("R6 no redirect", 64'(redirect_o), 64'h0);
        wr("R6 rearm", 2'd1, 64'h3);
        idle("R6 user", 1'b1, 64'h5004);
        chk("R6 dropped", 64'(redirect_o), 64'h0);

        // R8: every alert line on its own
        for (int i = 0; i < NA; i++) begin
            wr("R8 ctl", 2'd0, 64'h9);
            step("R8 alert line", NA'(1) << i, 1'b0, 64'h0, 1'b0, 2'd0, 64'h0);
            chk("R8 ctl after line", ctl_o, 64'h11);
        end

        // R9: write in the alert cycle is used
        wr("R9 ctl clear", 2'd0, 64'h0);
        step("R9 write+alert", 5'b10000, 1'b0, 64'h0, 1'b1, 2'd0, 64'h3);
        chk("R9 written ctl used", ctl_o, 64'h5);
        // R9: status write loses to hardware on redirect
        step("R9 stat write+service", '0, 1'b1, 64'h6000, 1'b1, 2'd1, 64'h3);
        chk("R9 redirect", 64'(redirect_o), 64'h1);
        chk("R9 status hw wins", stat_o, 64'h6);

        // R10: alert during service re-arms pending
        wr("R10 arm", 2'd1, 64'h3);
        step("R10 alert", 5'b00001, 1'b0, 64'h0, 1'b0, 2'd0, 64'h0);
        step("R10 service+alert", 5'b01000, 1'b1, 64'h7000, 1'b0, 2'd0, 64'h0);
        chk("R10 first redirect", 64'(redirect_o), 64'h1);
        wr("R10 rearm", 2'd1, 64'h3);
        chk("R10 no redirect in supervisor", 64'(redirect_o), 64'h0);
        idle("R10 user", 1'b1, 64'h7100);
        chk("R10 second redirect", 64'(redirect_o), 64'h1);
        chk("R10 return", ret_o, 64'h7100);

        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            logic [NA-1:0] al;
            logic          w;
            logic [1:0]    s;
            logic [63:0]   d;
            al = ($urandom % 4 == 0) ? NA'($urandom) : '0;
            w  = ($urandom % 4 == 0);
            s  = 2'($urandom);
            d  = (s < 2'd2) ? 64'($urandom % 32) : {$urandom, $urandom};
            step("R9 random mix", al, 1'($urandom), {$urandom, $urandom}, w, s, d);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule